// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on a host I/O port bus and converts accesses to two 32-bit ports into configuration-space transactions toward the devices of a hierarchical bus. One port, at I/O address 0xCF8, is an address latch. The other port, at 0xCFC, is a data window. Software first writes a packed address word to the latch. That word names a bus, a device, a function and a dword inside the 256-byte configuration space of that function, and it carries an enable bit. A read or write of the data window then runs one configuration cycle on a simple request/acknowledge interface, and the dword moves through unchanged.

Each configuration cycle has a bounded wait. A function that does not acknowledge within that window is treated as absent, so a read from it returns all ones. Software uses this to tell empty slots apart, because an all-ones vendor word is never valid. The host side holds its ready signal low until the cycle completes, so only one configuration cycle is outstanding at any time. Address-port accesses, accesses while the enable bit is clear, and accesses to any other I/O address complete without waiting.

Top module: `cfg_port_bridge`

## Requirements
- R1: A write to the address port (io_addr == 0xCF8) completes in the same cycle and stores the written word with bits 30..24 and 1..0 forced to zero. A read of that port returns the stored word.
- R2: While a configuration cycle runs, cfg_bus carries address bits 23..16, cfg_dev bits 15..11, cfg_fn bits 10..8 and cfg_dw bits 7..2 of the stored address word.
- R3: When the stored bit 31 is set, a read of the data port (io_addr == 0xCFC) starts exactly one configuration read, and the acknowledged cfg_rdata is returned on io_rdata without any byte reordering.
- R4: When bit 31 is set, a write of the data port starts exactly one configuration write with cfg_we = 1, and io_wdata is presented unchanged on cfg_wdata.
- R5: When bit 31 is clear, a data-port access completes in the same cycle and starts no configuration cycle. A read returns 0xFFFFFFFF and a write is dropped.
- R6: If cfg_ack stays low for TIMEOUT request cycles, the cycle ends as absent. A read returns 0xFFFFFFFF, and the host access completes TIMEOUT+1 cycles after it was presented.
- R7: An acknowledge that arrives in the last allowed request cycle wins over the expiry, and its data is returned.
- R8: io_ready stays low from the start of a configuration cycle until it completes. An acknowledge seen in request cycle k (counted from 0) completes the host access k+2 cycles after it was presented, and the request fields stay stable while waiting.
- R9: An access to any other I/O address completes in the same cycle, returns 0xFFFFFFFF on a read, and has no effect.
- R10: After reset, the stored address word is zero (enable clear) and no configuration cycle is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host access request, held until io_ready |
| io_we | input | 1 | Host access is a write |
| io_addr | input | IO_AW | Host I/O port address |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, valid while io_ready is high |
| io_ready | output | 1 | Access completes on a clock edge where io_req and io_ready are both high |
| cfg_req | output | 1 | Configuration cycle request |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dw | output | 6 | Dword index inside the configuration space |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Responder acknowledge |
| cfg_rdata | input | 32 | Responder read data, valid with cfg_ack |

## Verification
The acknowledge from a responder and the expiry of the wait counter can fall in the same cycle. The bench provokes this by forcing its device model to answer in the last allowed request cycle, and then one cycle later. It judges the outcome by the data returned, either the responder's dword or all ones, and by the completion cycle counted at the host port. A second overlap is a host data-port access that arrives in the cycle right after an address write. The near-exhaustive bus/device/function sweep produces this case on every step, and checks that the new target fields are the ones the responder sees.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_ready,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_fn,
  output logic [5:0]       cfg_dw,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic [31:0]      cfg_rdata
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [31:0] KEEP = 32'h80FF_FFFC;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t st;
  logic [31:0] addr_q, data_q, rsp_q;
  logic we_q;
  logic [CW-1:0] cnt;

  wire hit_a  = (io_addr == ADDR_PORT);
  wire hit_d  = (io_addr == DATA_PORT);
  wire launch = (st == S_IDLE) && io_req && hit_d && addr_q[31];
  wire expire = (cnt == CW'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      data_q <= '0;
      rsp_q  <= '1;
      we_q   <= 1'b0;
      cnt    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (io_req && hit_a && io_we) addr_q <= io_wdata & KEEP;
          if (launch) begin
            st     <= S_BUSY;
            cnt    <= '0;
            data_q <= io_wdata;
            we_q   <= io_we;
          end
        end
        S_BUSY: begin
          if (cfg_ack) begin
            rsp_q <= cfg_rdata;
            st    <= S_DONE;
          end else if (expire) begin
            rsp_q <= '1;
            st    <= S_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign io_ready  = ((st == S_IDLE) && !launch) || (st == S_DONE);
  assign io_rdata  = (st == S_DONE) ? rsp_q : (hit_a ? addr_q : '1);
  assign cfg_req   = (st == S_BUSY);
  assign cfg_we    = we_q;
  assign cfg_bus   = addr_q[23:16];
  assign cfg_dev   = addr_q[15:11];
  assign cfg_fn    = addr_q[10:8];
  assign cfg_dw    = addr_q[7:2];
  assign cfg_wdata = data_q;
endmodule

module cfg_port_bridge_chk #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC,
  parameter int TIMEOUT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_req,
  input logic             io_we,
  input logic [IO_AW-1:0] io_addr,
  input logic [31:0]      io_wdata,
  input logic [31:0]      io_rdata,
  input logic             io_ready,
  input logic             cfg_req,
  input logic             cfg_ack,
  input logic [7:0]       cfg_bus,
  input logic [4:0]       cfg_dev,
  input logic [2:0]       cfg_fn,
  input logic [5:0]       cfg_dw,
  input logic [31:0]      cfg_wdata,
  input logic             cfg_we,
  input logic [31:0]      addr_q
);
  localparam logic [31:0] KEEP = 32'h80FF_FFFC;
  int req_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) req_cnt <= 0;
    else if (cfg_req) req_cnt <= req_cnt + 1;
    else req_cnt <= 0;
  end

  assert_addr_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_ready && !io_we && io_addr == ADDR_PORT) |-> ((io_rdata & ~KEEP) == 32'h0));

  assert_addr_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_ready && io_we && io_addr == ADDR_PORT && !cfg_req) |=> (addr_q == ($past(io_wdata) & KEEP)));

  assert_fields_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> $stable({cfg_bus, cfg_dev, cfg_fn, cfg_dw, cfg_we, cfg_wdata}));

  assert_wait_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !io_ready);

  assert_ack_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack) |=> !cfg_req);

  assert_bounded_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (req_cnt < TIMEOUT));

  assert_gate_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req) |-> addr_q[31]);

  assert_disabled_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_addr == DATA_PORT && !addr_q[31] && !cfg_req) |-> (io_ready && (io_we || io_rdata == 32'hFFFF_FFFF)));

  assert_other_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_addr != DATA_PORT && io_addr != ADDR_PORT && !cfg_req) |-> (io_ready && (io_we || io_rdata == 32'hFFFF_FFFF)));
endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(
  .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .TIMEOUT(TIMEOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready), .cfg_req(cfg_req),
  .cfg_ack(cfg_ack), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
  .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .addr_q(addr_q)
);

// File: tb/tb_cfg_port_bridge.sv
`timescale 1ns/1ps
module tb_cfg_port_bridge;
  localparam int TO = 16;
  localparam logic [15:0] AP = 16'h0CF8;
  localparam logic [15:0] DP = 16'h0CFC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0, io_rdata;
  logic io_ready;
  logic cfg_req, cfg_we;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [5:0] cfg_dw;
  logic [31:0] cfg_wdata;
  logic cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  always #4 clk = ~clk;

  cfg_port_bridge #(.IO_AW(16), .ADDR_PORT(AP), .DATA_PORT(DP), .TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_dw(cfg_dw), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata));

  int ncmp = 0, nbad = 0;
  int force_lat = -1;
  bit mute = 1'b0;

  function automatic logic [31:0] pat(int b, int d, int f, int w);
    return {8'(b), 5'(d), 3'(f), 6'(w), 2'b01, 8'hC3};
  endfunction
  function automatic bit present(int b, int d, int f);
    return ((b + d + f) % 3) == 0;
  endfunction
  function automatic bit is_tgt(int b, int d, int f);
    return b == 0 && d == 3 && f == 0;
  endfunction
  function automatic int lat_of(int d, int w);
    return (d + w) % 4;
  endfunction

  // responder model
  logic [31:0] tgt_mem [64];
  logic [63:0] tgt_wr = '0;
  int mcnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      cfg_ack <= 1'b0;
      mcnt <= 0;
    end else if (cfg_req && !cfg_ack && !mute && present(int'(cfg_bus), int'(cfg_dev), int'(cfg_fn))) begin
      if (mcnt == ((force_lat >= 0) ? force_lat : lat_of(int'(cfg_dev), int'(cfg_dw)))) begin
        cfg_ack <= 1'b1;
        mcnt <= 0;
        if (is_tgt(int'(cfg_bus), int'(cfg_dev), int'(cfg_fn))) begin
          if (cfg_we) begin
            tgt_mem[cfg_dw] <= cfg_wdata;
            tgt_wr[cfg_dw] <= 1'b1;
          end
          cfg_rdata <= tgt_wr[cfg_dw] ? tgt_mem[cfg_dw] : pat(0, 3, 0, int'(cfg_dw));
        end else begin
          cfg_rdata <= pat(int'(cfg_bus), int'(cfg_dev), int'(cfg_fn), int'(cfg_dw));
        end
      end else begin
        mcnt <= mcnt + 1;
      end
    end else begin
      cfg_ack <= 1'b0;
      if (!cfg_req) mcnt <= 0;
    end
  end

  // request monitor
  int nreq = 0;
  logic req_prev = 1'b0;
  logic [21:0] cap = '0;
  logic cap_we = 1'b0;
  logic [31:0] cap_wd = '0;
  always @(posedge clk) begin
    req_prev <= cfg_req;
    if (cfg_req && !req_prev) begin
      nreq <= nreq + 1;
      cap <= {cfg_bus, cfg_dev, cfg_fn, cfg_dw};
      cap_we <= cfg_we;
      cap_wd <= cfg_wdata;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [15:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_wdata = wd;
    cyc = 0;
    #1;
    while (!io_ready && cyc < TO + 10) begin
      @(negedge clk); #1;
      cyc++;
    end
    rd = io_rdata;
    @(posedge clk);
    #1 io_req = 1'b0;
  endtask

  function automatic logic [31:0] mk(bit en, int b, int d, int f, int w);
    return {en, 7'h00, 8'(b), 5'(d), 3'(f), 6'(w), 2'b00};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    ncmp++; nbad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd, exp_mem [64];
    int cyc, n0;
    for (int w = 0; w < 64; w++) exp_mem[w] = pat(0, 3, 0, w);
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    chk("R10 cfg_req idle", 32'(cfg_req), 32'h0);
    xfer(1'b0, AP, '0, rd, cyc);
    chk("R10 address word after reset", rd, 32'h0);

    // R1 masking and immediate completion
    xfer(1'b1, AP, 32'hFFFF_FFFF, rd, cyc);
    chk("R1 address write cycles", 32'(cyc), 32'd0);
    xfer(1'b0, AP, '0, rd, cyc);
    chk("R1 readback all-ones write", rd, 32'h80FF_FFFC);
    xfer(1'b1, AP, 32'h7F12_3457, rd, cyc);
    xfer(1'b0, AP, '0, rd, cyc);
    chk("R1 readback reserved set", rd, 32'h0012_3454);

    // R5 disabled data port
    n0 = nreq;
    xfer(1'b0, DP, '0, rd, cyc);
    chk("R5 disabled read data", rd, 32'hFFFF_FFFF);
    chk("R5 disabled read cycles", 32'(cyc), 32'd0);
    xfer(1'b1, AP, mk(1'b0, 0, 3, 0, 5), rd, cyc);
    xfer(1'b1, DP, 32'hDEAD_BEEF, rd, cyc);
    chk("R5 disabled write cycles", 32'(cyc), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 no config cycle", 32'(nreq - n0), 32'd0);

    // R9 other port
    xfer(1'b1, 16'h0CF9, 32'h1234_5678, rd, cyc);
    xfer(1'b0, 16'h0CF9, '0, rd, cyc);
    chk("R9 other port read", rd, 32'hFFFF_FFFF);
    chk("R9 other port cycles", 32'(cyc), 32'd0);
    xfer(1'b0, AP, '0, rd, cyc);
    chk("R9 address word untouched", rd, mk(1'b0, 0, 3, 0, 5));

    // R2 R3 R6 R8 near-exhaustive sweep of buses 0..2
    for (int b = 0; b < 3; b++)
      for (int d = 0; d < 32; d++)
        for (int f = 0; f < 8; f++) begin
          int w;
          w = (d * 2 + f) % 64;
          xfer(1'b1, AP, mk(1'b1, b, d, f, w) | 32'h0300_0003, rd, cyc);
          n0 = nreq;
          xfer(1'b0, DP, '0, rd, cyc);
          chk("R3 one config cycle per read", 32'(nreq - n0), 32'd1);
          chk("R2 decoded fields", {10'h0, cap}, {10'h0, 8'(b), 5'(d), 3'(f), 6'(w)});
          if (present(b, d, f)) begin
            chk("R3 read data", rd, is_tgt(b, d, f) ? exp_mem[w] : pat(b, d, f, w));
            chk("R8 completion cycles", 32'(cyc), 32'(lat_of(d, w) + 3));
          end else begin
            chk("R6 absent read data", rd, 32'hFFFF_FFFF);
            chk("R6 absent cycles", 32'(cyc), 32'(TO + 1));
          end
        end

    // R4 writes to the target function
    for (int w = 0; w < 64; w++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (w + 1) ^ 32'(w << 24);
      xfer(1'b1, AP, mk(1'b1, 0, 3, 0, w), rd, cyc);
      n0 = nreq;
      xfer(1'b1, DP, v, rd, cyc);
      chk("R4 one config write", 32'(nreq - n0), 32'd1);
      chk("R4 write flag", 32'(cap_we), 32'd1);
      chk("R4 write data unchanged", cap_wd, v);
      exp_mem[w] = v;
    end
    for (int w = 0; w < 64; w++) begin
      xfer(1'b1, AP, mk(1'b1, 0, 3, 0, w), rd, cyc);
      xfer(1'b0, DP, '0, rd, cyc);
      chk("R4 readback", rd, exp_mem[w]);
    end

    // R5 dropped write leaves target unchanged
    xfer(1'b1, AP, mk(1'b0, 0, 3, 0, 9), rd, cyc);
    xfer(1'b1, DP, 32'h0BAD_F00D, rd, cyc);
    xfer(1'b1, AP, mk(1'b1, 0, 3, 0, 9), rd, cyc);
    xfer(1'b0, DP, '0, rd, cyc);
    chk("R5 dropped write", rd, exp_mem[9]);

    // R7 ack in last allowed cycle versus one cycle late
    force_lat = TO - 2;
    xfer(1'b1, AP, mk(1'b1, 0, 3, 0, 10), rd, cyc);
    xfer(1'b0, DP, '0, rd, cyc);
    chk("R7 late ack data", rd, exp_mem[10]);
    chk("R7 late ack cycles", 32'(cyc), 32'(TO + 1));
    force_lat = TO - 1;
    xfer(1'b0, DP, '0, rd, cyc);
    chk("R6 ack past window data", rd, 32'hFFFF_FFFF);
    chk("R6 ack past window cycles", 32'(cyc), 32'(TO + 1));
    force_lat = -1;

    // R6 write to a silent responder completes and changes nothing
    mute = 1'b1;
    xfer(1'b1, AP, mk(1'b1, 0, 3, 0, 11), rd, cyc);
    xfer(1'b1, DP, 32'h5555_AAAA, rd, cyc);
    chk("R6 silent write cycles", 32'(cyc), 32'(TO + 1));
    mute = 1'b0;
    xfer(1'b0, DP, '0, rd, cyc);
    chk("R6 silent write no effect", rd, exp_mem[11]);

    summary();
    $finish;
  end
endmodule